// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block keeps the pending-interrupt flags and the interrupt enable mask of a small peripheral with timers and a serial shift unit. The neighbouring datapaths report events as single-cycle set pulses. The block merges those pulses with register writes and clearing reads to maintain a 7-bit flag register and a 7-bit enable register. From these it drives one interrupt request line.

Software reaches the block through a plain register port: a 4-bit index, a write strobe, a read strobe, write data, and combinational read data. There is no data stream here, so no valid/ready handshake is used. A strobe acts on the rising clock edge at the end of the cycle in which it is high. Read data is valid during that same cycle. Register indices that the block does not own return zero and do not change its state. The one exception is the shift-data index, whose read clears the shift-related flags.

Top module: `intr_flag_ctrl`

## Requirements
- R1: After reset both registers are zero: the flag index (0xD) reads 0x00, the enable index (0xE) reads 0x80, and `irq` is low.
- R2: A pulse on `src_pulse[k]` sets flag bit k+2 at the next clock edge. The bit positions are: shift complete at bit 2, shift data at bit 3, shift clock at bit 4, timer 2 at bit 5 and timer 1 at bit 6.
- R3: A write to index 0xD clears each flag bit 6:0 that is 1 in the written data. Bit 7 of the written data has no effect, and flags written with 0 are unchanged.
- R4: A write to index 0xE with data bit 7 = 1 ORs data bits 6:0 into the enable mask.
- R5: A write to index 0xE with data bit 7 = 0 clears each enable bit that is 1 in data bits 6:0.
- R6: A read of index 0xE returns the enable mask in bits 6:0 with bit 7 always 1.
- R7: A read of index 0xD returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag in bits 6:0 is set together with its enable, including the shift-data and shift-clock bits.
- R8: `irq` is high exactly when flag AND enable is nonzero under mask 0x64 (bits 2, 5, 6). Enabled shift-data or shift-clock flags alone do not raise it.
- R9: A read of index 0xA clears flag bits 2, 3 and 4 and leaves bits 5 and 6 unchanged.
- R10: A pulse on `tmr_ack[0]` clears the timer 1 flag (bit 6), and a pulse on `tmr_ack[1]` clears the timer 2 flag (bit 5).
- R11: When a set pulse and any clear for the same flag fall in the same cycle, the flag ends up set.
- R12: Writes to and reads of any other index leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (the read of index 0xA has a side effect) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for indices 0xD and 0xE, zero otherwise |
| src_pulse | input | 5 | Event set pulses, bit k sets flag bit k+2 |
| tmr_ack | input | 2 | Timer flag clear pulses: [0] timer 1, [1] timer 2 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the collisions: a set pulse in the same cycle as a flag-register write, an acknowledge, or a shift-data read aimed at the same bit. The bench drives each collision by placing the pulse and the clearing strobe in one driver call, so both land on the same edge. It then reads the flag register to confirm the bit survived. The summary bit is also checked separately from `irq`. Only the shift-data and shift-clock flags are enabled at first, so bit 7 rises while the line stays low.

// File: rtl/intr_flag_pkg.sv
package intr_flag_pkg;
  localparam int REG_W     = 8;
  localparam int MASK_W    = REG_W - 1;
  localparam int IDX_W     = 4;
  localparam int NUM_SRC   = 5;
  localparam int SRC_LSB   = 2;
  localparam int NUM_TMR   = 2;
  localparam logic [IDX_W-1:0] IDX_SHIFT = 4'hA;
  localparam logic [IDX_W-1:0] IDX_FLAG  = 4'hD;
  localparam logic [IDX_W-1:0] IDX_EN    = 4'hE;
  localparam int BIT_T1 = 6;
  localparam int BIT_T2 = 5;
  localparam logic [MASK_W-1:0] SHIFT_GRP = 7'h1C;
  localparam logic [MASK_W-1:0] IRQ_MASK  = 7'h64;
endpackage

// File: rtl/intr_flag_reg.sv
module intr_flag_reg
  import intr_flag_pkg::*;
#(
  parameter int W = MASK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);
  // set dominates a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R11
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((flags & $past(clr_vec) & ~$past(set_vec)) == '0)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(flags)); // R12
endmodule

// File: rtl/intr_enable_reg.sv
module intr_enable_reg
  import intr_flag_pkg::*;
#(
  parameter int W = MASK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W:0]   wd,
  output logic [W-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (we) begin
      if (wd[W])    en <= en | wd[W-1:0];
      else          en <= en & ~wd[W-1:0];
    end
  end

  AST_EN_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wd[W]) |=> ((en & $past(wd[W-1:0])) == $past(wd[W-1:0]))); // R4
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wd[W]) |=> ((en & $past(wd[W-1:0])) == '0)); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en)); // R12
endmodule

// File: rtl/intr_summary.sv
module intr_summary
  import intr_flag_pkg::*;
#(
  parameter int          W    = MASK_W,
  parameter logic [W-1:0] MASK = IRQ_MASK
) (
  input  logic [W-1:0] flags,
  input  logic [W-1:0] en,
  output logic         any_pend,
  output logic         irq
);
  logic [W-1:0] live;
  always_comb begin
    live     = flags & en;
    any_pend = |live;
    irq      = |(live & MASK);
  end
endmodule

// File: rtl/intr_flag_ctrl.sv
module intr_flag_ctrl
  import intr_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic [NUM_TMR-1:0] tmr_ack,
  output logic              irq
);
  logic [MASK_W-1:0] flags, en, set_vec, clr_vec;
  logic              any_pend;
  logic              wr_flag, wr_en, rd_shift;

  always_comb begin
    wr_flag  = reg_wr && (reg_idx == IDX_FLAG);
    wr_en    = reg_wr && (reg_idx == IDX_EN);
    rd_shift = reg_rd && (reg_idx == IDX_SHIFT);
  end

  // source k lands on flag bit k+SRC_LSB
  always_comb begin
    set_vec = '0;
    for (int k = 0; k < NUM_SRC; k++) set_vec[k+SRC_LSB] = src_pulse[k];
  end

  always_comb begin
    clr_vec = '0;
    if (wr_flag)    clr_vec = clr_vec | reg_wdata[MASK_W-1:0];
    if (rd_shift)   clr_vec = clr_vec | SHIFT_GRP;
    if (tmr_ack[0]) clr_vec[BIT_T1] = 1'b1;
    if (tmr_ack[1]) clr_vec[BIT_T2] = 1'b1;
  end

  intr_flag_reg #(.W(MASK_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags));

  intr_enable_reg #(.W(MASK_W)) u_en (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .wd(reg_wdata), .en(en));

  intr_summary #(.W(MASK_W), .MASK(IRQ_MASK)) u_sum (
    .flags(flags), .en(en), .any_pend(any_pend), .irq(irq));

  always_comb begin
    unique case (reg_idx)
      IDX_FLAG: reg_rdata = {any_pend, flags};
      IDX_EN:   reg_rdata = {1'b1, en};
      default:  reg_rdata = '0;
    endcase
  end

  AST_SHIFT_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_shift && src_pulse[2:0] == '0) |=> (flags[4:2] == '0)); // R9
  AST_ACK_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ack[0] && !src_pulse[4]) |=> !flags[BIT_T1]); // R10
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(src_pulse[0] | src_pulse[3] | src_pulse[4] | reg_wr)); // R8
endmodule

// File: tb/test_intr_flag_ctrl.sv
module test_intr_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_idx = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [4:0] src_pulse = '0;
  logic [1:0] tmr_ack = '0;
  logic       irq;

  int n_run = 0, n_fail = 0;
  logic mon_chk = 1'b0;
  bit   done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    bit         is_irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  intr_flag_ctrl i_intr_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_pulse(src_pulse),
    .tmr_ack(tmr_ack), .irq(irq));

  // driver: one bus cycle, optional expected item pushed to the scoreboard
  task automatic cyc(input bit wr, input bit rd, input logic [3:0] idx,
                     input logic [7:0] wd, input logic [4:0] src,
                     input logic [1:0] ack, input bit chk, input bit is_irq,
                     input logic [7:0] exp, input string tag);
    exp_t it;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_idx = idx; reg_wdata = wd;
    src_pulse = src; tmr_ack = ack; mon_chk = chk;
    if (chk) begin
      it.exp = exp; it.is_irq = is_irq; it.tag = tag;
      sb.push_back(it);
    end
  endtask

  task automatic rd_chk(input logic [3:0] idx, input logic [7:0] exp, input string tag);
    cyc(0, 1, idx, 8'h00, 5'd0, 2'd0, 1, 0, exp, tag);
  endtask
  task automatic irq_chk(input bit exp, input string tag);
    cyc(0, 0, 4'h0, 8'h00, 5'd0, 2'd0, 1, 1, {7'd0, exp}, tag);
  endtask
  task automatic wr(input logic [3:0] idx, input logic [7:0] wd);
    cyc(1, 0, idx, wd, 5'd0, 2'd0, 0, 0, 8'h00, "");
  endtask

  // monitor: samples between the driving negedge and the next posedge
  always begin
    @(negedge clk);
    #1;
    if (mon_chk && sb.size() > 0) begin
      exp_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {7'd0, irq} : reg_rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(4'hD, 8'h00, "R1 flag reset");
    rd_chk(4'hE, 8'h80, "R1 R6 enable reset");
    irq_chk(0, "R1 irq reset");
    // all five sources
    cyc(0, 0, 4'h0, 8'h00, 5'b11111, 2'd0, 0, 0, 8'h00, "");
    rd_chk(4'hD, 8'h7C, "R2 flags set, R7 no summary");
    irq_chk(0, "R8 nothing enabled");
    wr(4'hE, 8'h98);
    rd_chk(4'hE, 8'h98, "R4 R6 enable set");
    rd_chk(4'hD, 8'hFC, "R7 summary via data/clock bits");
    irq_chk(0, "R8 data/clock do not drive irq");
    wr(4'hE, 8'h84);
    irq_chk(1, "R8 shift complete drives irq");
    rd_chk(4'hE, 8'h9C, "R4 OR accumulates");
    // shift-data read clears shift group
    cyc(0, 1, 4'hA, 8'h00, 5'd0, 2'd0, 0, 0, 8'h00, "");
    rd_chk(4'hD, 8'h60, "R9 shift read clears bits 4:2");
    irq_chk(0, "R8 irq drops");
    wr(4'hE, 8'hE0);
    irq_chk(1, "R8 timers enabled");
    rd_chk(4'hD, 8'hE0, "R7 summary timers");
    wr(4'hE, 8'h20);
    rd_chk(4'hE, 8'hDC, "R5 enable clear");
    cyc(0, 0, 4'h0, 8'h00, 5'd0, 2'b01, 0, 0, 8'h00, "");
    rd_chk(4'hD, 8'h20, "R10 timer1 ack");
    irq_chk(0, "R8 t2 flag not enabled");
    cyc(0, 0, 4'h0, 8'h00, 5'd0, 2'b10, 0, 0, 8'h00, "");
    rd_chk(4'hD, 8'h00, "R10 timer2 ack");
    // collisions
    cyc(0, 0, 4'h0, 8'h00, 5'b10000, 2'b01, 0, 0, 8'h00, "");
    rd_chk(4'hD, 8'hC0, "R11 set beats ack");
    irq_chk(1, "R8 timer1 irq");
    cyc(1, 0, 4'hD, 8'h40, 5'b10000, 2'd0, 0, 0, 8'h00, "");
    rd_chk(4'hD, 8'hC0, "R11 set beats flag write");
    cyc(0, 0, 4'h0, 8'h00, 5'b01000, 2'd0, 0, 0, 8'h00, "");
    wr(4'hD, 8'hC0);
    rd_chk(4'hD, 8'h20, "R3 write-one clears, bit7 ignored");
    cyc(0, 1, 4'hA, 8'h00, 5'b00001, 2'd0, 0, 0, 8'h00, "");
    rd_chk(4'hD, 8'hA4, "R11 set beats shift read");
    irq_chk(1, "R8 bit2 enabled");
    // other indices
    wr(4'h3, 8'hFF);
    wr(4'hB, 8'h7F);
    cyc(0, 1, 4'h4, 8'h00, 5'd0, 2'd0, 0, 0, 8'h00, "");
    rd_chk(4'hD, 8'hA4, "R12 flags untouched");
    rd_chk(4'hE, 8'hDC, "R12 enables untouched");
    cyc(0, 0, 4'h0, 8'h00, 5'd0, 2'd0, 0, 0, 8'h00, "");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule